// File: doc/BRIEF.md
# Full-Bridge PWM Gate Generator with Shoot-Through Lockout

This block drives the four power switches of a single-phase full bridge. A signed modulation sample sets the duty cycle of the left leg's high-side switch; the right leg is driven with the complementary duty, so the bridge output follows the sample. Both duties are compared against a symmetric up/down carrier counter. The compare values are reloaded only when the carrier is at its trough, so a pulse is never cut short partway through a period. On each leg the high and low switches take turns. A programmable number of clock cycles of blanking, with both switches off, is inserted at every change of side.

After the dead-time logic there is a lockout stage. It checks the final request for each leg, whether that request comes from the PWM path or from an external override vector. If both switches of one leg would be on, that leg's outputs are held off and a sticky fault flag is raised. Dropping enable turns every gate off on the next clock.

Top module: `hbridge_pwm_top`

## Requirements
- R1: The two gates of one leg (left high/low, right high/low) are never high in the same cycle.
- R2: A side change on a leg leaves both of its gates low for exactly `dead_cyc` cycles before the new side turns on. Over one full carrier period (2·`period_cyc` cycles) with an on-pulse and an off-pulse present, the high gate is on for (raw − `dead_cyc`) cycles and the low gate for (2·`period_cyc` − raw − `dead_cyc`) cycles.
- R3: The carrier counts 0,1,…,P,P−1,…,1 and repeats, with P = `period_cyc`. The left compare value C is ((mod + 32768)·(P+1)) >> 16. The left high-side request is active while the carrier count is below C, so raw = min(C,P+1) + max(0, min(C,P) − 1).
- R4: The right leg's compare value is (P+1) − C, so its high-side duty is the inverse of the left leg's.
- R5: Saturation: mod = +32767 gives C = P+1, which holds the left high gate on and the right low gate on with no blanking. mod = −32768 gives C = 0, the mirror case.
- R6: A new modulation value takes effect only at the next carrier trough (count 0). Pulses already under way in the current period use the old value.
- R7: While `force_en` is high, `force_gates` replaces the PWM request: bit 0 left high, bit 1 left low, bit 2 right high, bit 3 right low. A leg whose two bits are both set gets both gates low. Any other pattern passes to the gates on the next clock.
- R8: `fault` rises on the clock after a both-on request on a leg while enabled, and it stays high until reset.
- R9: With `enable` low, all four gates are low from the next clock on, and a both-on request does not raise `fault`.
- R10: After reset, all gates and `fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low forces all gates off |
| mod_in | input | 16 | Signed modulation sample |
| period_cyc | input | 16 | Carrier peak count P |
| dead_cyc | input | 8 | Blanking length in clock cycles |
| force_en | input | 1 | Selects the override vector instead of PWM |
| force_gates | input | 4 | Override gate request {RL, RU, LL, LU} |
| gate_lu | output | 1 | Left leg high-side gate |
| gate_ll | output | 1 | Left leg low-side gate |
| gate_ru | output | 1 | Right leg high-side gate |
| gate_rl | output | 1 | Right leg low-side gate |
| fault | output | 1 | Sticky shoot-through request flag |

## Verification
The lockout check and the enable gate act on the same registered gate request, so the two can coincide in one cycle. The bench provokes this by driving `enable` low in the same cycle as a both-on override of the left leg. On the next clock it expects all gates low and `fault` still low. In a separate case it raises `fault` with the block enabled, then checks that a legal override pattern reaches the gates while the flag stays set.

// File: rtl/hb_pkg.sv
package hb_pkg;
    localparam int HB_MOD_W = 16;
    localparam int HB_CNT_W = 16;
    localparam int HB_DT_W  = 8;
    localparam int HB_LEGS  = 2;

    // Bit positions inside the override vector
    localparam int OV_LU = 0;
    localparam int OV_LL = 1;
    localparam int OV_RU = 2;
    localparam int OV_RL = 3;
endpackage

// File: rtl/hb_carrier.sv
module hb_carrier #(
    parameter int CW = hb_pkg::HB_CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] cnt,
    output logic          trough
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          up;
    } car_t;

    car_t car_d, car_q;

    always_comb begin
        car_d = car_q;
        if (!en) begin
            car_d.cnt = '0;
            car_d.up  = 1'b1;
        end else if (car_q.up) begin
            if (car_q.cnt >= period) begin
                car_d.up  = 1'b0;
                car_d.cnt = (car_q.cnt == '0) ? '0 : car_q.cnt - 1'b1;
            end else begin
                car_d.cnt = car_q.cnt + 1'b1;
            end
        end else begin
            if (car_q.cnt <= CW'(1)) begin
                car_d.cnt = '0;
                car_d.up  = 1'b1;
            end else begin
                car_d.cnt = car_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) car_q <= '{cnt: '0, up: 1'b1};
        else        car_q <= car_d;
    end

    assign cnt    = car_q.cnt;
    assign trough = (car_q.cnt == '0);

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (car_q.cnt <= period) && $stable(period) |=> (car_q.cnt <= period));
endmodule

// File: rtl/hb_duty.sv
module hb_duty #(
    parameter int MW = hb_pkg::HB_MOD_W,
    parameter int CW = hb_pkg::HB_CNT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trough,
    input  logic signed [MW-1:0] mod_in,
    input  logic [CW-1:0]        period,
    output logic [CW:0]          cmp_l,
    output logic [CW:0]          cmp_r
);
    localparam logic [MW-1:0] MAX_POS = {1'b0, {(MW-1){1'b1}}};

    typedef struct packed {
        logic [CW:0] l;
        logic [CW:0] r;
    } cmp_t;

    cmp_t cmp_d, cmp_q;

    function automatic logic [CW:0] scale(input logic [MW-1:0] u, input logic [CW:0] span);
        logic [MW+CW:0] prod;
        prod  = {{(CW+1){1'b0}}, u} * {{MW{1'b0}}, span};
        return prod[MW+CW:MW];
    endfunction

    logic [MW-1:0] offs;
    logic [CW:0]   span;
    logic [CW:0]   left_c;

    always_comb begin
        offs   = {~mod_in[MW-1], mod_in[MW-2:0]};
        span   = {1'b0, period} + 1'b1;
        left_c = (mod_in == MAX_POS) ? span : scale(offs, span);
        cmp_d  = cmp_q;
        if (trough) begin
            cmp_d.l = left_c;
            cmp_d.r = span - left_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_q <= '0;
        else        cmp_q <= cmp_d;
    end

    assign cmp_l = cmp_q.l;
    assign cmp_r = cmp_q.r;

    // R6
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trough |=> $stable(cmp_q));
endmodule

// File: rtl/hb_leg.sv
module hb_leg #(
    parameter int CW = hb_pkg::HB_CNT_W,
    parameter int DW = hb_pkg::HB_DT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] cnt,
    input  logic [CW:0]   cmp,
    input  logic [DW-1:0] dead,
    input  logic          ovr_en,
    input  logic          ovr_hi,
    input  logic          ovr_lo,
    output logic          hi,
    output logic          lo,
    output logic          clash
);
    typedef struct packed {
        logic          side;
        logic [DW-1:0] dcnt;
        logic          hi;
        logic          lo;
    } leg_t;

    leg_t leg_d, leg_q;
    logic raw_hi, want_hi, want_lo;

    always_comb begin
        raw_hi = ({1'b0, cnt} < cmp);
        leg_d  = leg_q;
        if (!en) begin
            leg_d.side = 1'b0;
            leg_d.dcnt = dead;
        end else if (raw_hi != leg_q.side) begin
            leg_d.side = raw_hi;
            leg_d.dcnt = dead;
        end else if (leg_q.dcnt != '0) begin
            leg_d.dcnt = leg_q.dcnt - 1'b1;
        end

        want_hi = (leg_d.dcnt == '0) &&  leg_d.side;
        want_lo = (leg_d.dcnt == '0) && !leg_d.side;
        if (ovr_en) begin
            want_hi = ovr_hi;
            want_lo = ovr_lo;
        end

        clash    = en && want_hi && want_lo;
        leg_d.hi = en && want_hi && !want_lo;
        leg_d.lo = en && want_lo && !want_hi;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) leg_q <= '{side: 1'b0, dcnt: '0, hi: 1'b0, lo: 1'b0};
        else        leg_q <= leg_d;
    end

    assign hi = leg_q.hi;
    assign lo = leg_q.lo;

    // R1
    no_shoot_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(leg_q.hi && leg_q.lo));

    // R9
    off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!leg_q.hi && !leg_q.lo));
endmodule

// File: rtl/hbridge_pwm_top.sv
module hbridge_pwm_top #(
    parameter int MOD_W = hb_pkg::HB_MOD_W,
    parameter int CNT_W = hb_pkg::HB_CNT_W,
    parameter int DT_W  = hb_pkg::HB_DT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable,
    input  logic signed [MOD_W-1:0] mod_in,
    input  logic [CNT_W-1:0]        period_cyc,
    input  logic [DT_W-1:0]         dead_cyc,
    input  logic                    force_en,
    input  logic [3:0]              force_gates,
    output logic                    gate_lu,
    output logic                    gate_ll,
    output logic                    gate_ru,
    output logic                    gate_rl,
    output logic                    fault
);
    import hb_pkg::*;

    logic [CNT_W-1:0] cnt;
    logic             trough;
    logic [CNT_W:0]   cmp_l, cmp_r;
    logic [CNT_W:0]   cmp_a   [HB_LEGS];
    logic             ovr_hi  [HB_LEGS];
    logic             ovr_lo  [HB_LEGS];
    logic             leg_hi  [HB_LEGS];
    logic             leg_lo  [HB_LEGS];
    logic             leg_clash [HB_LEGS];
    logic             fault_d, fault_q;

    hb_carrier #(.CW(CNT_W)) u_carrier (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (enable),
        .period (period_cyc),
        .cnt    (cnt),
        .trough (trough)
    );

    hb_duty #(.MW(MOD_W), .CW(CNT_W)) u_duty (
        .clk    (clk),
        .rst_n  (rst_n),
        .trough (trough),
        .mod_in (mod_in),
        .period (period_cyc),
        .cmp_l  (cmp_l),
        .cmp_r  (cmp_r)
    );

    assign cmp_a[0]  = cmp_l;
    assign cmp_a[1]  = cmp_r;
    assign ovr_hi[0] = force_gates[OV_LU];
    assign ovr_lo[0] = force_gates[OV_LL];
    assign ovr_hi[1] = force_gates[OV_RU];
    assign ovr_lo[1] = force_gates[OV_RL];

    for (genvar g = 0; g < HB_LEGS; g++) begin : g_leg
        hb_leg #(.CW(CNT_W), .DW(DT_W)) u_leg (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (enable),
            .cnt    (cnt),
            .cmp    (cmp_a[g]),
            .dead   (dead_cyc),
            .ovr_en (force_en),
            .ovr_hi (ovr_hi[g]),
            .ovr_lo (ovr_lo[g]),
            .hi     (leg_hi[g]),
            .lo     (leg_lo[g]),
            .clash  (leg_clash[g])
        );
    end

    always_comb begin
        fault_d = fault_q | leg_clash[0] | leg_clash[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= fault_d;
    end

    assign gate_lu = leg_hi[0];
    assign gate_ll = leg_lo[0];
    assign gate_ru = leg_hi[1];
    assign gate_rl = leg_lo[1];
    assign fault   = fault_q;

    // R8
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_q |=> fault_q);

    // R7
    clash_blocks_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_en && enable && force_gates[OV_LU] && force_gates[OV_LL])
            |=> (!gate_lu && !gate_ll && fault));
endmodule

// File: tb/tb_hbridge_pwm_top.sv
module tb_hbridge_pwm_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic signed [15:0] mod_in;
    logic [15:0] period_cyc;
    logic [7:0]  dead_cyc;
    logic        force_en;
    logic [3:0]  force_gates;
    logic        gate_lu, gate_ll, gate_ru, gate_rl, fault;

    int n_tests = 0;
    int n_fail  = 0;
    int overlap = 0;

    always #4 clk = ~clk;

    hbridge_pwm_top dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mod_in(mod_in),
        .period_cyc(period_cyc), .dead_cyc(dead_cyc), .force_en(force_en),
        .force_gates(force_gates), .gate_lu(gate_lu), .gate_ll(gate_ll),
        .gate_ru(gate_ru), .gate_rl(gate_rl), .fault(fault)
    );

    always @(negedge clk)
        if ((gate_lu && gate_ll) || (gate_ru && gate_rl)) overlap++;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int left_cmp(input int m, input int p);
        if (m == 32767) return p + 1;
        return ((m + 32768) * (p + 1)) >>> 16;
    endfunction

    function automatic int raw_on(input int c, input int p);
        int a, b;
        a = (c < p + 1) ? c : p + 1;
        b = ((c < p) ? c : p) - 1;
        if (b < 0) b = 0;
        return a + b;
    endfunction

    function automatic int on_cycles(input int raw, input int p, input int d);
        if (raw == 0) return 0;
        if (raw == 2 * p) return 2 * p;
        return raw - d;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; enable = 1'b0; mod_in = '0; period_cyc = 16'd20;
        dead_cyc = 8'd3; force_en = 1'b0; force_gates = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R10 gates", int'({gate_lu, gate_ll, gate_ru, gate_rl}), 0);
        check("R10 fault", int'(fault), 0);
    endtask

    task automatic t_duty(input int m, input int p, input int d, input string tag);
        int cl, cr, rl, rr, lu, ll, ru, rlc;
        @(negedge clk);
        mod_in = 16'(m); period_cyc = 16'(p); dead_cyc = 8'(d); enable = 1'b1;
        repeat (6 * p + 10) @(negedge clk);
        lu = 0; ll = 0; ru = 0; rlc = 0;
        for (int i = 0; i < 2 * p; i++) begin
            lu += int'(gate_lu); ll += int'(gate_ll);
            ru += int'(gate_ru); rlc += int'(gate_rl);
            @(negedge clk);
        end
        cl = left_cmp(m, p);
        cr = p + 1 - cl;
        rl = raw_on(cl, p);
        rr = raw_on(cr, p);
        check({tag, " R3 left high"},  lu,  on_cycles(rl, p, d));
        check({tag, " R2 left low"},   ll,  on_cycles(2 * p - rl, p, d));
        check({tag, " R4 right high"}, ru,  on_cycles(rr, p, d));
        check({tag, " R2 right low"},  rlc, on_cycles(2 * p - rr, p, d));
    endtask

    task automatic t_trough();
        int c, cntv;
        logic prev;
        do_reset();
        @(negedge clk);
        mod_in = 16'sd16384; period_cyc = 16'd40; dead_cyc = 8'd3; enable = 1'b1;
        repeat (300) @(negedge clk);
        prev = gate_lu;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (prev && !gate_lu) break;
            prev = gate_lu;
        end
        mod_in = -16'sd32768;
        c = left_cmp(16384, 40);
        cntv = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            cntv += int'(gate_lu);
        end
        check("R6 old value finishes period", cntv, c - 3);
        cntv = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            cntv += int'(gate_lu);
        end
        check("R5/R6 new min value applied", cntv, 0);
    endtask

    task automatic t_override();
        do_reset();
        enable = 1'b1;
        repeat (5) @(negedge clk);
        force_en = 1'b1; force_gates = 4'b0011;
        @(negedge clk);
        check("R7 clash leg off", int'({gate_lu, gate_ll}), 0);
        check("R7 other leg follows", int'({gate_ru, gate_rl}), 0);
        check("R8 fault set", int'(fault), 1);
        force_gates = 4'b1001;
        @(negedge clk);
        check("R7 legal pattern passes", int'({gate_rl, gate_ru, gate_ll, gate_lu}), 9);
        check("R8 fault stays", int'(fault), 1);
        force_en = 1'b0;
        repeat (50) @(negedge clk);
        check("R8 fault sticky", int'(fault), 1);
        do_reset();
        check("R8 fault cleared by reset", int'(fault), 0);
    endtask

    task automatic t_enable_clash();
        do_reset();
        force_en = 1'b1; force_gates = 4'b0100; enable = 1'b1;
        @(negedge clk);
        check("R7 right high via override", int'(gate_ru), 1);
        enable = 1'b0; force_gates = 4'b0011;
        @(negedge clk);
        check("R9 all off same cycle as clash", int'({gate_lu, gate_ll, gate_ru, gate_rl}), 0);
        check("R9 no fault while disabled", int'(fault), 0);
        force_en = 1'b0; enable = 1'b1; mod_in = 16'sd32767;
        repeat (100) @(negedge clk);
        check("R5 full duty running", int'(gate_lu), 1);
        enable = 1'b0;
        @(negedge clk);
        check("R9 gates off next clock", int'({gate_lu, gate_ll, gate_ru, gate_rl}), 0);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #1500000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_duty(0, 20, 3, "mid");
        t_duty(16384, 20, 3, "pos");
        t_duty(-20000, 50, 5, "neg");
        t_duty(32767, 20, 3, "R5 max");
        t_duty(-32768, 20, 3, "R5 min");
        check("R1 no overlap in PWM runs", overlap, 0);
        t_trough();
        t_override();
        t_enable_clash();
        check("R1 no overlap overall", overlap, 0);
        finish_run();
    end
endmodule